// File: doc/BRIEF.md
# Bit-Serial Two's Complement Subtractor

This block forms the difference A - B of two signed words of `WIDTH` bits that arrive one bit per clock, lowest-weight bit first. Each clock it returns one bit of the difference in the same cycle as the operand bits that produce it. The output is a Mealy function of the stored state and the present input bits. There are no operand registers. The block keeps two bits of state, the running carry and a flag that records whether a 1 of B has already been seen. Together with a bit-position counter, these are all the storage the arithmetic needs.

The block does not invert B and inject a carry of one. It negates B on the fly. B bits pass through unchanged up to and including the first 1 of B. From then on every later B bit is inverted before it enters the addition. The running sum of A and the negated B is the difference. On the final bit of each word the block raises an overflow flag when the true signed difference does not fit in `WIDTH` bits.

A `start` pulse marks bit 0 of a new word and discards any state left over. After the last bit of a word the block returns to the fresh state by itself, so words can follow back to back without `start`. A synchronous reset also leaves the block ready for bit 0.

Top module: `bitser_sub`

## Requirements
- R1: Over the `WIDTH` bits of a word, the bits on `d_bit`, taken lowest weight first, equal (A - B) modulo 2^WIDTH. Each bit appears combinationally in the same cycle as the `a_bit` and `b_bit` that produce it.
- R2: A cycle with `start` high is treated as bit 0 of a new word, whatever state the previous cycles left. In that cycle, `a_bit`=0 with `b_bit`=0 gives `d_bit`=0.
- R3: In the first clock after `rst` (synchronous, active high) is released, the block treats the input as bit 0 of a word without any `start` pulse.
- R4: While no 1 of B has yet appeared in the current word, B passes through unchanged. A bit with `b_bit`=1 in that span is the first 1 of B and gives `d_bit` = NOT `a_bit`.
- R5: Every B bit after the first 1 of B is inverted before it is added to the A bit and the carry.
- R6: `ovf` can be high only in the cycle of bit `WIDTH`-1. In that cycle it is high exactly when the signed difference A - B lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1. For example, `ovf` is high for B equal to the most negative value whenever A is zero or positive.
- R7: While every B bit seen so far in the word is 0, `d_bit` equals `a_bit`, so B = 0 reproduces A.
- R8: The cycle after bit `WIDTH`-1 is bit 0 of the next word even without `start`, with the carry and the first-one flag cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Marks bit 0 of a new word |
| a_bit | input | 1 | Serial minuend bit, lowest weight first |
| b_bit | input | 1 | Serial subtrahend bit, lowest weight first |
| d_bit | output | 1 | Serial difference bit, same cycle as the inputs |
| ovf | output | 1 | Signed overflow, valid on the last bit of a word |

## Verification
The bench builds three copies of the block, with `WIDTH` = 4, 8 and 6. At 4 bits, all 256 operand pairs can be applied, so every first-one position and every overflow combination is covered exhaustively. At 8 bits, a table of corner vectors (including the most negative B, zero B and limit values of A) runs alongside random pairs, back-to-back words, a mid-word restart and a word that begins straight after reset. The 6-bit copy is the only one that exercises the counter variant for word lengths that are not a power of two.

// File: rtl/bitser_sub_pkg.sv
package bitser_sub_pkg;

   // state carried between bit times of one word
   typedef struct packed {
      logic carry;
      logic seen;
   } sub_state_t;

   localparam sub_state_t SUB_FRESH = '{carry: 1'b0, seen: 1'b0};

   function automatic logic maj3(input logic x, input logic y, input logic z);
      return (x & y) | (x & z) | (y & z);
   endfunction

   function automatic int unsigned pos_bits(input int unsigned width);
      return (width < 2) ? 1 : $clog2(width);
   endfunction

endpackage

// File: rtl/bitser_sub_poscnt.sv
module bitser_sub_poscnt #(
   parameter int unsigned WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic at_last
);
   import bitser_sub_pkg::*;

   localparam int unsigned CW = pos_bits(WIDTH);
   localparam logic [CW-1:0] LAST_POS = CW'(WIDTH - 1);
   localparam bit POW2 = (WIDTH == (1 << CW));

   logic [CW-1:0] pos_q;
   logic [CW-1:0] pos_eff;
   logic [CW-1:0] pos_nxt;

   assign pos_eff = restart ? '0 : pos_q;
   assign at_last = (pos_eff == LAST_POS);

   generate
      if (POW2) begin : g_wrap_free
         // counter rolls over to zero on its own after the last bit
         assign pos_nxt = pos_eff + CW'(1);
      end else begin : g_wrap_cmp
         assign pos_nxt = at_last ? '0 : pos_eff + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pos_q <= '0;
      else     pos_q <= pos_nxt;
   end
endmodule

// File: rtl/bitser_sub_negate.sv
module bitser_sub_negate (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic word_end,
   input  logic b_bit,
   output logic nb_bit
);
   logic seen_q;
   logic seen_eff;

   // before the first 1 of B pass it through; after it invert
   assign seen_eff = restart ? 1'b0 : seen_q;
   assign nb_bit   = b_bit ^ seen_eff;

   always_ff @(posedge clk) begin
      if (rst)           seen_q <= 1'b0;
      else if (word_end) seen_q <= 1'b0;
      else               seen_q <= seen_eff | b_bit;
   end
endmodule

// File: rtl/bitser_sub_adder.sv
module bitser_sub_adder (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic word_end,
   input  logic x_bit,
   input  logic y_bit,
   output logic s_bit
);
   import bitser_sub_pkg::*;

   logic cy_q;
   logic cy_eff;

   assign cy_eff = restart ? 1'b0 : cy_q;
   assign s_bit  = x_bit ^ y_bit ^ cy_eff;

   always_ff @(posedge clk) begin
      if (rst)           cy_q <= 1'b0;
      else if (word_end) cy_q <= 1'b0;
      else               cy_q <= maj3(x_bit, y_bit, cy_eff);
   end
endmodule

// File: rtl/bitser_sub.sv
module bitser_sub #(
   parameter int unsigned WIDTH = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic a_bit,
   input  logic b_bit,
   output logic d_bit,
   output logic ovf
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bitser_sub: WIDTH must be at least 2");
      end
   endgenerate

   logic last_bit;
   logic nb_bit;
   logic sum_bit;

   bitser_sub_poscnt #(.WIDTH(WIDTH)) u_pos (
      .clk     (clk),
      .rst     (rst),
      .restart (start),
      .at_last (last_bit)
   );

   bitser_sub_negate u_neg (
      .clk      (clk),
      .rst      (rst),
      .restart  (start),
      .word_end (last_bit),
      .b_bit    (b_bit),
      .nb_bit   (nb_bit)
   );

   bitser_sub_adder u_add (
      .clk      (clk),
      .rst      (rst),
      .restart  (start),
      .word_end (last_bit),
      .x_bit    (a_bit),
      .y_bit    (nb_bit),
      .s_bit    (sum_bit)
   );

   assign d_bit = sum_bit;
   // signed overflow of A - B: operand signs differ and result sign leaves A's
   assign ovf   = last_bit & (a_bit ^ b_bit) & (sum_bit ^ a_bit);
endmodule

// File: rtl/bitser_sub_chk.sv
module bitser_sub_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic clk,
   input logic rst,
   input logic start,
   input logic a_bit,
   input logic b_bit,
   input logic d_bit,
   input logic ovf
);
   int unsigned pos_q;
   int unsigned pos_eff;
   logic        one_q;
   logic        fresh;

   assign pos_eff = start ? 0 : pos_q;
   assign fresh   = start | ~one_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos_q <= 0;
         one_q <= 1'b0;
      end else if (pos_eff == WIDTH - 1) begin
         pos_q <= 0;
         one_q <= 1'b0;
      end else begin
         pos_q <= pos_eff + 1;
         one_q <= ~fresh | b_bit;
      end
   end

   AST_RESTART_CLEAN: assert property (@(posedge clk) disable iff (rst)
      start && !a_bit && !b_bit |-> !d_bit); // R2
   AST_FIRST_ONE_FLIPS: assert property (@(posedge clk) disable iff (rst)
      fresh && b_bit |-> d_bit == !a_bit); // R4
   AST_ZERO_B_COPIES: assert property (@(posedge clk) disable iff (rst)
      fresh && !b_bit |-> d_bit == a_bit); // R7
   AST_OVF_LAST_ONLY: assert property (@(posedge clk) disable iff (rst)
      pos_eff != WIDTH - 1 |-> !ovf); // R6
   AST_OVF_SIGNS: assert property (@(posedge clk) disable iff (rst)
      ovf |-> (a_bit != b_bit) && (d_bit != a_bit)); // R6
endmodule

bind bitser_sub bitser_sub_chk #(.WIDTH(WIDTH)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .start (start),
   .a_bit (a_bit),
   .b_bit (b_bit),
   .d_bit (d_bit),
   .ovf   (ovf)
);

// File: tb/bitser_sub_test.sv
module bitser_sub_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic st [3];
   logic ab [3];
   logic bb [3];
   logic dv [3];
   logic ov [3];

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   localparam logic [15:0] VEC [16] = '{
      16'h0000, 16'h7F80, 16'h8080, 16'h0080, 16'hFF80, 16'h8001,
      16'h55AA, 16'h1200, 16'h0001, 16'h7FFF, 16'h807F, 16'hFFFF,
      16'h0100, 16'h3CC3, 16'h7F7F, 16'h8000
   };

   always #4 clk = ~clk;

   bitser_sub #(.WIDTH(4)) uut4 (.clk(clk), .rst(rst), .start(st[0]), .a_bit(ab[0]),
      .b_bit(bb[0]), .d_bit(dv[0]), .ovf(ov[0]));
   bitser_sub #(.WIDTH(8)) uut (.clk(clk), .rst(rst), .start(st[1]), .a_bit(ab[1]),
      .b_bit(bb[1]), .d_bit(dv[1]), .ovf(ov[1]));
   bitser_sub #(.WIDTH(6)) uut6 (.clk(clk), .rst(rst), .start(st[2]), .a_bit(ab[2]),
      .b_bit(bb[2]), .d_bit(dv[2]), .ovf(ov[2]));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // apply bits without checking (used to leave state behind)
   task automatic drive_bits(input int sel, input int n, input logic [7:0] av, bv);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rst = 1'b0; st[sel] = 1'b0; ab[sel] = av[i]; bb[sel] = bv[i];
      end
   endtask

   task automatic run_word(input int sel, input int w, input logic [7:0] av, bv,
                           input bit use_start, input string req);
      logic [7:0] got = '0;
      logic gov = 1'b0;
      logic mid = 1'b0;
      int sa, sb, r, emax, emin;
      logic [7:0] mask, exp_d;
      bit exp_o;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         rst = 1'b0;
         st[sel] = use_start && (i == 0);
         ab[sel] = av[i];
         bb[sel] = bv[i];
         #1;
         got[i] = dv[sel];
         if (i == w - 1) gov = ov[sel];
         else if (ov[sel]) mid = 1'b1;
      end
      mask  = 8'((1 << w) - 1);
      exp_d = (av - bv) & mask;
      sa = int'(av & mask); if (av[w-1]) sa -= (1 << w);
      sb = int'(bv & mask); if (bv[w-1]) sb -= (1 << w);
      r = sa - sb;
      emax = (1 << (w - 1)) - 1;
      emin = -(1 << (w - 1));
      exp_o = (r > emax) || (r < emin);
      check(got == exp_d, {req, " R1 difference"}, int'(got), int'(exp_d));
      check(gov == exp_o, {req, " R6 overflow"}, int'(gov), int'(exp_o));
      check(!mid, {req, " R6 overflow before last bit"}, int'(mid), 0);
   endtask

   initial begin
      for (int k = 0; k < 3; k++) begin st[k] = 0; ab[k] = 0; bb[k] = 0; end
      rst = 1'b1;
      repeat (3) @(negedge clk);

      // R3: first word straight after reset, no start pulse
      run_word(1, 8, 8'h5A, 8'h33, 1'b0, "R3 after reset");

      // table of corner vectors, 8-bit (R4 R5 R6 R7)
      for (int v = 0; v < 16; v++)
         run_word(1, 8, VEC[v][15:8], VEC[v][7:0], 1'b1, "R5 table");

      // R7: zero subtrahend reproduces A
      run_word(1, 8, 8'hC7, 8'h00, 1'b1, "R7 zero B");
      // R4: first 1 of B at the top bit, most negative B
      run_word(1, 8, 8'h00, 8'h80, 1'b1, "R4 first one at msb");

      // R8: back-to-back words, no start on the second and third
      run_word(1, 8, 8'h7F, 8'h01, 1'b1, "R8 word A");
      run_word(1, 8, 8'h01, 8'h7F, 1'b0, "R8 word B");
      run_word(1, 8, 8'h80, 8'h01, 1'b0, "R8 word C");

      // R2: abandon a half word that left carry and first-one set
      drive_bits(1, 3, 8'hFF, 8'hFF);
      run_word(1, 8, 8'h10, 8'h20, 1'b1, "R2 restart");

      // R3: reset in the middle of a word
      drive_bits(1, 5, 8'hFF, 8'h01);
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      run_word(1, 8, 8'h20, 8'h10, 1'b0, "R3 mid-word reset");

      // exhaustive at 4 bits
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            run_word(0, 4, 8'(a), 8'(b), 1'b1, "R1 exhaustive4");

      // random at 8 bits
      for (int k = 0; k < 200; k++)
         run_word(1, 8, 8'($urandom), 8'($urandom), 1'b1, "R1 random8");

      // non power of two word length
      for (int k = 0; k < 60; k++)
         run_word(2, 6, 8'($urandom) & 8'h3F, 8'($urandom) & 8'h3F, (k % 3) == 0, "R8 width6");
      run_word(2, 6, 8'h00, 8'h20, 1'b1, "R6 width6 min B");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule